// File: doc/BRIEF.md
# Static Branch Direction Predictor

This block guesses whether a conditional branch will be taken, using only the branch's own address and its decoded target. It keeps no history. A front-end feeds it one branch per strobe. One clock later it returns a direction and the address to fetch next.

Two static rules can be selected. In the first, every branch is guessed not taken. In the second, a branch that jumps to a lower or equal address is guessed taken, and a branch that jumps forward is guessed not taken. This suits loops that close with a backward jump.

A direction hint carried by the instruction can replace the static rule. A companion dynamic predictor can also be attached. When it holds an entry for the branch, its direction is passed through. When it reports a miss, the static result, or the hint if one is present, is used instead.

Top module: `static_branch_predictor`

## Requirements
- R1: While rst_ni is low, and after its release until the first strobe, pred_valid_o, pred_taken_o and next_pc_o are all zero.
- R2: pred_valid_o is high in exactly the cycle after a cycle where br_valid_i was sampled high.
- R3: With mode_i = 0 (all-not-taken), dyn_miss_i = 1 and hint_valid_i = 0, the prediction is not taken for any pair of addresses.
- R4: With mode_i = 1 (direction by displacement), dyn_miss_i = 1 and hint_valid_i = 0, a target numerically lower than the branch address is predicted taken. The comparison is unsigned.
- R5: In the same setting as R4, a target equal to the branch address is predicted taken.
- R6: In the same setting as R4, a target numerically higher than the branch address is predicted not taken.
- R7: With dyn_miss_i = 1 and hint_valid_i = 1, the prediction equals hint_taken_i in both modes.
- R8: With dyn_miss_i = 0, the prediction equals dyn_taken_i. Mode, hint and addresses have no effect on it.
- R9: next_pc_o is the target when the prediction is taken. Otherwise it is the branch address plus 4, wrapping modulo 2^32.
- R10: In a cycle after br_valid_i was sampled low, pred_taken_o and next_pc_o keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| br_valid_i | input | 1 | A branch is presented this cycle |
| br_pc_i | input | 32 | Address of the branch |
| br_target_i | input | 32 | Decoded target address |
| hint_valid_i | input | 1 | The instruction carries a direction hint |
| hint_taken_i | input | 1 | Hinted direction, 1 = taken |
| mode_i | input | 1 | 0 = all not taken, 1 = backward taken / forward not taken |
| dyn_miss_i | input | 1 | The dynamic predictor has no entry for this branch |
| dyn_taken_i | input | 1 | Direction from the dynamic predictor, used on a hit |
| pred_valid_o | output | 1 | Prediction valid, one cycle after the strobe |
| pred_taken_o | output | 1 | Predicted direction |
| next_pc_o | output | 32 | Next fetch address |

## Verification
The only state is the output register. A wrong direction, a wrong source choice or a faulty comparator therefore shows up at the ports in the cycle right after the strobe. A register that loads without a strobe shows up as a changed output one cycle after an idle cycle.

Random traffic is mixed with directed cases. These cover equal addresses, the extremes of the address space, increment wrap, and each of hint, miss and mode acting against the others. Each response is compared with a model in the bench.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
  typedef enum logic {
    MODE_ALL_NT = 1'b0,
    MODE_BTFN   = 1'b1
  } sbp_mode_e;

  typedef enum logic [1:0] {
    SRC_RULE = 2'd0,
    SRC_HINT = 2'd1,
    SRC_DYN  = 2'd2
  } sbp_src_e;
endpackage

// File: rtl/sbp_dir_rule.sv
module sbp_dir_rule
  import sbp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  sbp_mode_e          mode_i,
  input  logic [ADDR_W-1:0]  pc_i,
  input  logic [ADDR_W-1:0]  target_i,
  output logic               taken_o
);
  logic backward;

  // equal target counts as backward (tight self-loop)
  assign backward = (target_i <= pc_i);

  always_comb begin
    unique case (mode_i)
      MODE_BTFN:   taken_o = backward;
      default:     taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/sbp_select.sv
module sbp_select
  import sbp_pkg::*;
(
  input  logic     rule_taken_i,
  input  logic     hint_valid_i,
  input  logic     hint_taken_i,
  input  logic     dyn_miss_i,
  input  logic     dyn_taken_i,
  output logic     taken_o,
  output sbp_src_e src_o
);
  always_comb begin
    if (!dyn_miss_i)       src_o = SRC_DYN;
    else if (hint_valid_i) src_o = SRC_HINT;
    else                   src_o = SRC_RULE;
  end

  always_comb begin
    unique case (src_o)
      SRC_DYN:  taken_o = dyn_taken_i;
      SRC_HINT: taken_o = hint_taken_i;
      default:  taken_o = rule_taken_i;
    endcase
  end
endmodule

// File: rtl/sbp_out_stage.sv
module sbp_out_stage #(
  parameter int ADDR_W     = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              taken_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic              valid_o,
  output logic              taken_o,
  output logic [ADDR_W-1:0] next_pc_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  logic [ADDR_W-1:0] seq_pc;
  logic [ADDR_W-1:0] fetch_pc;

  assign seq_pc   = pc_i + STEP;
  assign fetch_pc = taken_i ? target_i : seq_pc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_o   <= 1'b0;
      next_pc_o <= '0;
    end else if (valid_i) begin
      taken_o   <= taken_i;
      next_pc_o <= fetch_pc;
    end
  end

  assert_hold_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> ($stable(taken_o) && $stable(next_pc_o)));
endmodule

// File: rtl/static_branch_predictor.sv
module static_branch_predictor
  import sbp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              br_valid_i,
  input  logic [ADDR_W-1:0] br_pc_i,
  input  logic [ADDR_W-1:0] br_target_i,
  input  logic              hint_valid_i,
  input  logic              hint_taken_i,
  input  logic              mode_i,
  input  logic              dyn_miss_i,
  input  logic              dyn_taken_i,
  output logic              pred_valid_o,
  output logic              pred_taken_o,
  output logic [ADDR_W-1:0] next_pc_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  sbp_mode_e mode;
  logic      rule_taken;
  logic      sel_taken;
  sbp_src_e  sel_src;

  assign mode = sbp_mode_e'(mode_i);

  sbp_dir_rule #(.ADDR_W(ADDR_W)) u_rule (
    .mode_i   (mode),
    .pc_i     (br_pc_i),
    .target_i (br_target_i),
    .taken_o  (rule_taken)
  );

  sbp_select u_sel (
    .rule_taken_i (rule_taken),
    .hint_valid_i (hint_valid_i),
    .hint_taken_i (hint_taken_i),
    .dyn_miss_i   (dyn_miss_i),
    .dyn_taken_i  (dyn_taken_i),
    .taken_o      (sel_taken),
    .src_o        (sel_src)
  );

  sbp_out_stage #(.ADDR_W(ADDR_W), .INSN_BYTES(INSN_BYTES)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (br_valid_i),
    .taken_i   (sel_taken),
    .pc_i      (br_pc_i),
    .target_i  (br_target_i),
    .valid_o   (pred_valid_o),
    .taken_o   (pred_taken_o),
    .next_pc_o (next_pc_o)
  );

  assert_src_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_valid_i |-> (sel_src != 2'd3));

  assert_valid_delay_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_o == $past(br_valid_i));

  assert_all_nt_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(br_valid_i && !mode_i && dyn_miss_i && !hint_valid_i) |-> !pred_taken_o);

  assert_backward_taken_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(br_valid_i && mode_i && dyn_miss_i && !hint_valid_i && (br_target_i <= br_pc_i))
    |-> pred_taken_o);

  assert_forward_nt_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(br_valid_i && mode_i && dyn_miss_i && !hint_valid_i && (br_target_i > br_pc_i))
    |-> !pred_taken_o);

  assert_hint_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(br_valid_i && dyn_miss_i && hint_valid_i) |-> (pred_taken_o == $past(hint_taken_i)));

  assert_dyn_hit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(br_valid_i && !dyn_miss_i) |-> (pred_taken_o == $past(dyn_taken_i)));

  assert_next_pc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_o |-> (next_pc_o == (pred_taken_o ? $past(br_target_i) : $past(br_pc_i) + STEP)));
endmodule

// File: tb/static_branch_predictor_tb.sv
`timescale 1ns/1ps
module static_branch_predictor_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        br_valid = 1'b0;
  logic [31:0] br_pc = '0;
  logic [31:0] br_target = '0;
  logic        hint_valid = 1'b0;
  logic        hint_taken = 1'b0;
  logic        mode = 1'b0;
  logic        dyn_miss = 1'b1;
  logic        dyn_taken = 1'b0;
  logic        pred_valid;
  logic        pred_taken;
  logic [31:0] next_pc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  static_branch_predictor u_dut (
    .clk_i(clk), .rst_ni(rst_n), .br_valid_i(br_valid), .br_pc_i(br_pc),
    .br_target_i(br_target), .hint_valid_i(hint_valid), .hint_taken_i(hint_taken),
    .mode_i(mode), .dyn_miss_i(dyn_miss), .dyn_taken_i(dyn_taken),
    .pred_valid_o(pred_valid), .pred_taken_o(pred_taken), .next_pc_o(next_pc)
  );

  function automatic bit model_taken(bit m, logic [31:0] pc, logic [31:0] tg,
                                     bit hv, bit ht, bit miss, bit dt);
    if (!miss) return dt;
    if (hv)    return ht;
    if (!m)    return 1'b0;
    return (tg <= pc);
  endfunction

  function automatic logic [31:0] model_next(bit tk, logic [31:0] pc, logic [31:0] tg);
    return tk ? tg : pc + 32'd4;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, outputs checked at the following negedge
  task automatic branch(string req, bit m, logic [31:0] pc, logic [31:0] tg,
                        bit hv, bit ht, bit miss, bit dt);
    bit tk;
    @(negedge clk);
    br_valid = 1'b1; mode = m; br_pc = pc; br_target = tg;
    hint_valid = hv; hint_taken = ht; dyn_miss = miss; dyn_taken = dt;
    tk = model_taken(m, pc, tg, hv, ht, miss, dt);
    @(negedge clk);
    br_valid = 1'b0;
    check("R2", {31'd0, pred_valid}, 32'd1);
    check(req, {31'd0, pred_taken}, {31'd0, tk});
    check("R9", next_pc, model_next(tk, pc, tg));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit tk_prev;
    logic [31:0] np_prev;
    void'($urandom(32'h5eed_0042));
    #12;
    check("R1", {29'd0, pred_valid, pred_taken, 1'b0}, 32'd0);
    check("R1", next_pc, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {31'd0, pred_valid}, 32'd0);
    check("R1", next_pc, 32'd0);

    // R3: all-not-taken, even for a backward target
    branch("R3", 1'b0, 32'h0000_1000, 32'h0000_0800, 1'b0, 1'b0, 1'b1, 1'b0);
    branch("R3", 1'b0, 32'hFFFF_FFFC, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b0); // R9 wrap
    // R4 unsigned: 0x8000_0000 above 0x7FFF_FFF0
    branch("R4", 1'b1, 32'h8000_0000, 32'h7FFF_FFF0, 1'b0, 1'b0, 1'b1, 1'b0);
    branch("R4", 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b0);
    branch("R5", 1'b1, 32'h0000_2000, 32'h0000_2000, 1'b0, 1'b0, 1'b1, 1'b0);
    branch("R6", 1'b1, 32'h7FFF_FFF0, 32'h8000_0000, 1'b0, 1'b0, 1'b1, 1'b1);
    // R7: hint against the rule in both modes
    branch("R7", 1'b1, 32'h0000_3000, 32'h0000_2000, 1'b1, 1'b0, 1'b1, 1'b1);
    branch("R7", 1'b0, 32'h0000_3000, 32'h0000_4000, 1'b1, 1'b1, 1'b1, 1'b0);
    // R8: dynamic hit beats hint and rule
    branch("R8", 1'b1, 32'h0000_5000, 32'h0000_4000, 1'b1, 1'b1, 1'b0, 1'b0);
    branch("R8", 1'b0, 32'h0000_5000, 32'h0000_6000, 1'b1, 1'b0, 1'b0, 1'b1);

    // R10: idle cycle with changed inputs leaves outputs unchanged
    tk_prev = pred_taken; np_prev = next_pc;
    br_pc = 32'h1234_5678; br_target = 32'h0; dyn_miss = 1'b0; dyn_taken = ~tk_prev;
    @(negedge clk);
    check("R10", {31'd0, pred_valid}, 32'd0);
    check("R10", {31'd0, pred_taken}, {31'd0, tk_prev});
    check("R10", next_pc, np_prev);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] pc;
      logic [31:0] tg;
      bit m, hv, miss;
      pc = $urandom();
      case ($urandom_range(0, 3))
        0:       tg = pc;
        1:       tg = pc - $urandom_range(1, 4096);
        2:       tg = pc + $urandom_range(1, 4096);
        default: tg = $urandom();
      endcase
      m    = $urandom_range(0, 1) == 1;
      hv   = $urandom_range(0, 3) == 0;
      miss = $urandom_range(0, 2) != 0;
      branch(!miss ? "R8" : hv ? "R7" : !m ? "R3" : (tg < pc) ? "R4" : (tg == pc) ? "R5" : "R6",
             m, pc, tg, hv, $urandom_range(0, 1) == 1, miss, $urandom_range(0, 1) == 1);
      if ($urandom_range(0, 4) == 0) begin
        tk_prev = pred_taken; np_prev = next_pc;
        br_pc = $urandom(); br_target = $urandom();
        @(negedge clk);
        check("R10", {31'd0, pred_taken}, {31'd0, tk_prev});
        check("R10", next_pc, np_prev);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule